// File: doc/BRIEF.md
# Predicated Load Node with Ordering Token

This block is one memory-read operator in a circuit that executes a program as dataflow. It collects three operands on separate valid/ready channels: a read address, a Boolean guard and an ordering token that marks the completion of the preceding side-effecting operation. It does not start until all three are present. When the guard is true it issues one read on a synchronous memory port and forwards the returned word. When the guard is false it leaves memory untouched and forwards zero. In both cases it emits a fresh ordering token, so the next side-effecting operation in the chain stays behind this one.

The node never reads speculatively. A guard built by upstream logic from several control conditions, for example "second path taken and first path not taken", simply arrives on the guard channel as one bit. The node holds exactly one operation in flight. It acknowledges its three inputs together, only after both outputs have been taken downstream.

Top module: `plm_load_node`

## Requirements
- R1: After a synchronous active-high reset, all output valids, all input readies and the memory request are low.
- R2: No memory request and no output appear until the address, guard and token inputs are all valid at the same clock edge.
- R3: With the guard at 1, the node requests exactly one read at the presented address, and the data output carries the word that the memory returns one cycle after the request is granted.
- R4: With the guard at 0, the memory request stays low for the whole operation and the data output carries zero.
- R5: The outputs become valid 1 cycle after all inputs are valid for a false guard. For a true guard they become valid 3 cycles after all inputs are valid, plus one cycle for every cycle the grant is withheld.
- R6: The output token becomes valid in the same cycle as the data output, so for a true guard it never precedes completion of the read.
- R7: The three input readies rise together for exactly one cycle, and only after both the data output and the output token have been consumed.
- R8: While an output is valid and not ready, that output stays valid and its data stays unchanged.
- R9: While the memory request is high and the grant is low, the request stays high and the memory address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid_i | input | 1 | Address operand valid |
| addr_i | input | ADDR_W | Address operand |
| addr_ready_o | output | 1 | Address operand acknowledge |
| pred_valid_i | input | 1 | Guard operand valid |
| pred_i | input | 1 | Guard: 1 = perform the read, 0 = skip it |
| pred_ready_o | output | 1 | Guard operand acknowledge |
| tok_valid_i | input | 1 | Incoming ordering token |
| tok_ready_o | output | 1 | Incoming token acknowledge |
| data_valid_o | output | 1 | Result word valid |
| data_o | output | DATA_W | Result word (zero when the guard was 0) |
| data_ready_i | input | 1 | Downstream accepts the result |
| tokout_valid_o | output | 1 | Outgoing ordering token |
| tokout_ready_i | input | 1 | Downstream accepts the token |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DATA_W | Read word, valid one cycle after the grant |

## Verification
The assertions assume that a producer keeps each operand valid and unchanged until it is acknowledged, so the guard and address seen while the operation is in flight are those that started it. They also assume that the memory returns its word exactly one cycle after a grant. The bench drives every operand from a single task that changes nothing until the node raises its readies. It models the memory as a registered lookup that updates only on a granted request, and it varies token arrival delay, grant delay and output back-pressure between operations.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_OUT,
    ST_ACK
  } plm_state_e;
endpackage

// File: rtl/plm_slot.sv
module plm_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R8: a stalled output keeps its word
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(data));
endmodule

// File: rtl/plm_ctrl.sv
module plm_ctrl
  import plm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              all_valid,
  input  logic              pred,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              slots_empty,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              in_ready
);
  plm_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      in_ready <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (all_valid) begin
          if (pred) begin
            mem_req  <= 1'b1;
            mem_addr <= addr;
            st       <= ST_REQ;
          end else begin
            st <= ST_OUT;
          end
        end
        ST_REQ: if (mem_gnt) begin
          mem_req <= 1'b0;
          st      <= ST_WAIT;
        end
        ST_WAIT: st <= ST_OUT;
        ST_OUT: if (slots_empty) begin
          in_ready <= 1'b1;
          st       <= ST_ACK;
        end
        ST_ACK: begin
          in_ready <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign load      = (st == ST_IDLE && all_valid && !pred) || (st == ST_WAIT);
  assign load_data = (st == ST_WAIT) ? mem_rdata : '0;

  // R4: a request only exists for a true guard
  p_req_needs_pred_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> pred);
  // R2: a request only starts once every operand was present
  p_req_after_operands_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(all_valid));
  // R9: an ungranted request is held with its address
  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  // R7: acknowledge only after both outputs drained
  p_ack_after_drain_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> slots_empty);
  // R7: acknowledge lasts one cycle
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);
endmodule

// File: rtl/plm_load_node.sv
module plm_load_node #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              addr_ready_o,
  input  logic              pred_valid_i,
  input  logic              pred_i,
  output logic              pred_ready_o,
  input  logic              tok_valid_i,
  output logic              tok_ready_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              data_ready_i,
  output logic              tokout_valid_o,
  input  logic              tokout_ready_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              all_valid;
  logic              slots_empty;
  logic              load;
  logic [DATA_W-1:0] load_data;
  logic              in_ready;
  logic              tok_q;

  assign all_valid   = addr_valid_i && pred_valid_i && tok_valid_i;
  assign slots_empty = !data_valid_o && !tokout_valid_o;

  plm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .all_valid  (all_valid),
    .pred       (pred_i),
    .addr       (addr_i),
    .mem_gnt    (mem_gnt_i),
    .mem_rdata  (mem_rdata_i),
    .slots_empty(slots_empty),
    .mem_req    (mem_req_o),
    .mem_addr   (mem_addr_o),
    .load       (load),
    .load_data  (load_data),
    .in_ready   (in_ready)
  );

  plm_slot #(.W(DATA_W)) data_slot_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_data(load_data),
    .ready    (data_ready_i),
    .valid    (data_valid_o),
    .data     (data_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                          tok_q <= 1'b0;
    else if (load)                    tok_q <= 1'b1;
    else if (tok_q && tokout_ready_i) tok_q <= 1'b0;
  end

  assign tokout_valid_o = tok_q;
  assign addr_ready_o   = in_ready;
  assign pred_ready_o   = in_ready;
  assign tok_ready_o    = in_ready;

  // R6: token and result appear together
  p_token_with_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tokout_valid_o) |-> $rose(data_valid_o));
  // R8: a stalled token stays
  p_token_held_r8: assert property (@(posedge clk) disable iff (rst)
    tokout_valid_o && !tokout_ready_i |=> tokout_valid_o);
  // R2: no result without an incoming token being present
  p_out_needs_token_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid_o) |-> tok_valid_i);
endmodule

// File: tb/plm_load_node_tb.sv
module plm_load_node_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_valid_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          addr_ready_o;
  logic          pred_valid_i = 1'b0;
  logic          pred_i = 1'b0;
  logic          pred_ready_o;
  logic          tok_valid_i = 1'b0;
  logic          tok_ready_o;
  logic          data_valid_o;
  logic [DW-1:0] data_o;
  logic          data_ready_i = 1'b0;
  logic          tokout_valid_o;
  logic          tokout_ready_i = 1'b0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_gnt_i;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  int gnt_wait = 0;
  int req_cycles = 0;
  int req_count = 0;
  int op_active = 0;
  int op_pred = 0;
  logic [AW-1:0] op_addr = '0;
  int consumed = 0;

  always #2.5 clk = ~clk;

  plm_load_node #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return ({22'd0, a} * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  // Memory model: word returned one cycle after a granted request
  assign mem_gnt_i = mem_req_o && (req_cycles >= gnt_wait);
  always @(posedge clk) begin
    if (mem_req_o && mem_gnt_i) begin
      mem_rdata_i <= memf(mem_addr_o);
      req_count   <= req_count + 1;
      req_cycles  <= 0;
    end else if (mem_req_o) begin
      req_cycles <= req_cycles + 1;
    end else begin
      req_cycles <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock reference comparison
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req_o) begin
        chk(op_active == 1 && op_pred == 1, "R4 request only for true guard", mem_req_o, 0);
        chk(mem_addr_o == op_addr, "R3 request address", mem_addr_o, op_addr);
      end
      if (addr_ready_o)
        chk(consumed == 2 && pred_ready_o && tok_ready_o, "R7 ack after both outputs taken", consumed, 2);
      if (data_valid_o || tokout_valid_o)
        chk(op_active == 1, "R2 output only inside an operation", 0, 1);
    end
  end

  task automatic run_op(input logic [AW-1:0] a, input bit p, input int tok_delay,
                        input int gw, input int stall);
    int lat;
    logic [DW-1:0] exp_d;
    logic [DW-1:0] held;
    exp_d = p ? memf(a) : '0;
    gnt_wait = gw;
    consumed = 0;
    @(negedge clk);
    op_active = 1; op_pred = p; op_addr = a;
    addr_i = a; pred_i = p; addr_valid_i = 1'b1; pred_valid_i = 1'b1;
    for (int i = 0; i < tok_delay; i++) begin
      @(negedge clk);
      chk(!mem_req_o && !data_valid_o, "R2 wait for token", mem_req_o, 0);
    end
    tok_valid_i = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!data_valid_o && lat < 50);
    chk(lat == (p ? 3 + gw : 1), "R5 result latency", lat, p ? 3 + gw : 1);
    chk(data_o == exp_d, p ? "R3 loaded word" : "R4 zero for false guard", data_o, exp_d);
    chk(tokout_valid_o, "R6 token with result", tokout_valid_o, 1);
    chk(req_count == (p ? 1 : 0), "R3/R4 access count", req_count, p ? 1 : 0);
    held = data_o;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(data_valid_o && tokout_valid_o && data_o == held, "R8 stalled outputs held", data_o, held);
      chk(!addr_ready_o, "R7 no ack while outputs pending", addr_ready_o, 0);
    end
    tokout_ready_i = 1'b1;
    @(negedge clk);
    tokout_ready_i = 1'b0;
    consumed = 1;
    chk(!addr_ready_o && data_valid_o, "R7 no ack with data pending", addr_ready_o, 0);
    data_ready_i = 1'b1;
    @(negedge clk);
    data_ready_i = 1'b0;
    consumed = 2;
    lat = 0;
    while (!addr_ready_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(addr_ready_o, "R7 ack arrives", addr_ready_o, 1);
    @(negedge clk);
    addr_valid_i = 1'b0; pred_valid_i = 1'b0; tok_valid_i = 1'b0;
    chk(!addr_ready_o, "R7 ack lasts one cycle", addr_ready_o, 0);
    op_active = 0;
    req_count = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!data_valid_o && !tokout_valid_o && !mem_req_o && !addr_ready_o,
        "R1 reset state", {data_valid_o, tokout_valid_o, mem_req_o, addr_ready_o}, 0);
    rst = 1'b0;
    run_op(10'h021, 1'b1, 0, 0, 0);
    run_op(10'h3FF, 1'b0, 0, 0, 0);
    run_op(10'h155, 1'b1, 3, 2, 2);   // R9 grant withheld two cycles
    run_op(10'h0AA, 1'b0, 2, 0, 3);
    run_op(10'h000, 1'b1, 1, 4, 1);   // R9 longer grant stall
    run_op(10'h200, 1'b1, 0, 0, 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule